// File: doc/BRIEF.md
# Script Sequencer Run and Interrupt Control

This block holds the run-control byte of a script-driven DMA engine and decides when the engine may fetch its next instruction. The fetch address comes from an external script pointer. Software writes the control byte to choose single-step operation, to issue a start command, to pick the drive style of the interrupt pin and to mask that pin. A one-cycle instruction-done strobe stands in for execution of the fetched instruction.

The engine can run in three ways. In free-running operation, a load of the script pointer starts fetching. In manual-start operation, only the start bit starts fetching. In single-step operation, the sequencer halts after every instruction and raises a step interrupt; software then reads status and sets start again to continue. Interrupt conditions are latched as pending status. The mask bit only gates the active-low pin and never drops a pending condition. The pin drive can be push-pull or open-drain, with separate level and output-enable outputs.

Top module: `seq_run_ctl`

## Requirements
- R1: After reset the control byte reads 0x00, both pending flags are 0, irq_n_out is 1, irq_oe is 0, and fetch_req and busy are 0.
- R2: A control write loads single-step from bit 4, pin-drive mode from bit 3, start from bit 2 and pin mask from bit 1. Bits 7, 6, 5 and 0 are ignored and always read back as 0 on ctl_rdata, which uses the same bit positions.
- R3: When start reads 1, the sequencer is idle and nothing is pending, fetch_req goes high for exactly one cycle. This happens in the second cycle after the write, and fetch_addr equals script_ptr during that cycle.
- R4: With manual_mode at 1, a ptr_load pulse never starts fetching. With manual_mode at 0, a ptr_load pulse while idle raises fetch_req in the second cycle after the pulse.
- R5: With single-step clear, an instruction-done strobe while executing, with nothing pending and no new interrupt, raises fetch_req in the next cycle.
- R6: With single-step set, an instruction-done strobe while executing sets the step flag (int_status bit 0) in the next cycle and returns the sequencer to idle with no further fetch.
- R7: The start bit stays set while the engine runs. It clears in the same cycle that any pending flag is set, and this clear wins over a simultaneous write of 1.
- R8: An ext_irq pulse sets the external flag (int_status bit 1) in the next cycle. A sequencer that is executing finishes its current instruction and then goes idle without fetching.
- R9: A stat_rd pulse clears both pending flags in the next cycle. A flag that is being set in the same cycle stays set.
- R10: A stat_rd pulse and a write of start in the same cycle both take effect: the flags clear and a fetch follows in the second cycle.
- R11: While the mask bit is 1, irq_n_out stays 1 and pending flags are kept. Clearing the mask while a flag is pending drives irq_n_out to 0 in the cycle after the write.
- R12: With drive mode 1 (push-pull), irq_oe is the inverse of the mask bit. With drive mode 0 (open-drain), irq_oe is 1 only while irq_n_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| manual_mode | input | 1 | 1 selects manual-start operation |
| ptr_load | input | 1 | Script pointer was loaded (starts fetching in free-running operation) |
| script_ptr | input | ADDR_W | Current script pointer |
| instr_done | input | 1 | Current instruction completed |
| ext_irq | input | 1 | External interrupt condition pulse |
| stat_rd | input | 1 | Status read pulse, clears pending flags |
| fetch_req | output | 1 | Instruction fetch request |
| fetch_addr | output | ADDR_W | Fetch address, valid with fetch_req |
| busy | output | 1 | Sequencer is fetching or executing |
| int_status | output | 2 | Pending flags: bit 0 step, bit 1 external |
| irq_n_out | output | 1 | Active-low interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions check on every cycle the local laws of the block: fetch_req is a single-cycle pulse, the sequencer halts after a stepped instruction, and the start bit clears behind any new interrupt. They also check that pending flags never drop without a status read, and that the mask and the open-drain enable keep the pin consistent. Other behaviour is only visible in the bench scenarios. This covers the exact two-cycle start latency, the difference between manual and free-running start, the tie-break when a read coincides with a new interrupt or with a start write, and the resumption of single-step execution.

// File: rtl/seq_run_pkg.sv
package seq_run_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } run_st_e;

  // Bit positions of the control byte (decoded by software).
  localparam int unsigned CB_STEP  = 4;
  localparam int unsigned CB_PUSH  = 3;
  localparam int unsigned CB_START = 2;
  localparam int unsigned CB_MASK  = 1;

  typedef struct packed {
    logic step;
    logic push;
    logic start;
    logic mask;
  } ctl_t;

  // Pending flag indices.
  localparam int unsigned PF_STEP = 0;
  localparam int unsigned PF_EXT  = 1;
  localparam int unsigned PF_NUM  = 2;

endpackage

// File: rtl/seq_ctl_reg.sv
module seq_ctl_reg
  import seq_run_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              int_set,
  output ctl_t              ctl_o,
  output logic [DATA_W-1:0] rdata
);

  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.step  = wdata[CB_STEP];
      ctl_d.push  = wdata[CB_PUSH];
      ctl_d.start = wdata[CB_START];
      ctl_d.mask  = wdata[CB_MASK];
    end
    // A new interrupt retires the start command, over any write.
    if (int_set) ctl_d.start = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  always_comb begin
    rdata           = '0;
    rdata[CB_STEP]  = ctl_q.step;
    rdata[CB_PUSH]  = ctl_q.push;
    rdata[CB_START] = ctl_q.start;
    rdata[CB_MASK]  = ctl_q.mask;
  end

  assign ctl_o = ctl_q;

  // R7: start never survives an interrupt event
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_set |=> !ctl_q.start);

endmodule

// File: rtl/seq_run_fsm.sv
module seq_run_fsm
  import seq_run_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step_mode,
  input  logic              manual_mode,
  input  logic              ptr_load,
  input  logic              pend_any,
  input  logic              ext_irq,
  input  logic              instr_done,
  input  logic [ADDR_W-1:0] script_ptr,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              step_done,
  output logic              busy
);

  run_st_e st_q, st_d;
  logic    kick_q, kick_d;
  logic    launch;

  assign kick_d    = ptr_load & ~manual_mode;
  assign step_done = (st_q == ST_EXEC) & instr_done & step_mode;
  assign launch    = (start | kick_q) & ~pend_any & ~ext_irq;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (launch) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_EXEC;
      ST_EXEC: begin
        if (instr_done) begin
          if (step_mode || pend_any || ext_irq) st_d = ST_IDLE;
          else                                  st_d = ST_FETCH;
        end
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kick_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kick_q <= kick_d;
    end
  end

  assign fetch_req  = (st_q == ST_FETCH);
  assign fetch_addr = fetch_req ? script_ptr : '0;
  assign busy       = (st_q != ST_IDLE);

  // R3: a fetch request lasts one cycle
  p_fetch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

  // R5: free-running chains straight into the next fetch
  p_free_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC && instr_done && !step_mode && !pend_any && !ext_irq)
      |=> fetch_req);

  // R6: a stepped instruction ends in idle
  p_step_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC && instr_done && step_mode) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/seq_irq_status.sv
module seq_irq_status
  import seq_run_pkg::*;
#(
  parameter int unsigned NSRC = PF_NUM
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_ev,
  input  logic            clr,
  input  logic            mask,
  input  logic            push,
  output logic [NSRC-1:0] pend,
  output logic            irq_n_out,
  output logic            irq_oe
);

  logic [NSRC-1:0] pend_q, pend_d;
  logic            active;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    // Set wins over a clearing read in the same cycle.
    assign pend_d[i] = set_ev[i] | (pend_q[i] & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign active    = (|pend_q) & ~mask;
  assign irq_n_out = ~active;
  assign irq_oe    = push ? ~mask : active;
  assign pend      = pend_q;

  // R9: a read with no new event empties the flags
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_ev == '0) |=> (pend_q == '0));

  // R11: without a read, no flag is ever lost
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R11: masked pin stays released high
  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> irq_n_out);

  // R12: open-drain enables only to pull low
  p_open_drain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && irq_oe) |-> !irq_n_out);

endmodule

// File: rtl/seq_run_ctl.sv
module seq_run_ctl
  import seq_run_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              manual_mode,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] script_ptr,
  input  logic              instr_done,
  input  logic              ext_irq,
  input  logic              stat_rd,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              busy,
  output logic [PF_NUM-1:0] int_status,
  output logic              irq_n_out,
  output logic              irq_oe
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  ctl_t              ctl;
  logic              step_done;
  logic [PF_NUM-1:0] set_ev;
  logic              int_set;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    set_ev          = '0;
    set_ev[PF_STEP] = step_done;
    set_ev[PF_EXT]  = ext_irq;
  end
  assign int_set = |set_ev;

  seq_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (ctl_wr),
    .wdata   (ctl_wdata),
    .int_set (int_set),
    .ctl_o   (ctl),
    .rdata   (ctl_rdata)
  );

  seq_run_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (ctl.start),
    .step_mode   (ctl.step),
    .manual_mode (manual_mode),
    .ptr_load    (ptr_load),
    .pend_any    (|int_status),
    .ext_irq     (ext_irq),
    .instr_done  (instr_done),
    .script_ptr  (script_ptr),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .step_done   (step_done),
    .busy        (busy)
  );

  seq_irq_status #(.NSRC(PF_NUM)) u_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set_ev    (set_ev),
    .clr       (stat_rd),
    .mask      (ctl.mask),
    .push      (ctl.push),
    .pend      (int_status),
    .irq_n_out (irq_n_out),
    .irq_oe    (irq_oe)
  );

endmodule

// File: tb/seq_run_ctl_tb.sv
module seq_run_ctl_tb;

  localparam int unsigned ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_wr = 1'b0;
  logic [7:0]        ctl_wdata = '0;
  logic [7:0]        ctl_rdata;
  logic              manual_mode = 1'b0;
  logic              ptr_load = 1'b0;
  logic [ADDR_W-1:0] script_ptr = '0;
  logic              instr_done = 1'b0;
  logic              ext_irq = 1'b0;
  logic              stat_rd = 1'b0;
  logic              fetch_req;
  logic [ADDR_W-1:0] fetch_addr;
  logic              busy;
  logic [1:0]        int_status;
  logic              irq_n_out;
  logic              irq_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  seq_run_ctl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .manual_mode(manual_mode), .ptr_load(ptr_load),
    .script_ptr(script_ptr), .instr_done(instr_done), .ext_irq(ext_irq),
    .stat_rd(stat_rd), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .busy(busy), .int_status(int_status), .irq_n_out(irq_n_out), .irq_oe(irq_oe)
  );

  // {wdata, expected readback, irq_n_out, irq_oe} with the external flag pending
  localparam logic [17:0] VEC [0:6] = '{
    {8'h00, 8'h00, 2'b01},
    {8'h02, 8'h02, 2'b10},
    {8'h08, 8'h08, 2'b01},
    {8'h0A, 8'h0A, 2'b10},
    {8'hE1, 8'h00, 2'b01},
    {8'hFB, 8'h1A, 2'b10},
    {8'h19, 8'h18, 2'b01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One cycle of strobes: drive at a falling edge, release at the next.
  task automatic cyc(input bit wr, input logic [7:0] d, input bit rd,
                     input bit ext, input bit dn, input bit pl);
    ctl_wr = wr; ctl_wdata = d; stat_rd = rd;
    ext_irq = ext; instr_done = dn; ptr_load = pl;
    @(negedge clk);
    ctl_wr = 1'b0; stat_rd = 1'b0; ext_irq = 1'b0;
    instr_done = 1'b0; ptr_load = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", ctl_rdata, 8'h00);
    chk("R1 status", int_status, 2'b00);
    chk("R1 irq_n", irq_n_out, 1'b1);
    chk("R1 oe", irq_oe, 1'b0);
    chk("R1 fetch", fetch_req, 1'b0);
    chk("R1 busy", busy, 1'b0);

    // R8 external flag while idle
    cyc(0, 8'h00, 0, 1, 0, 0);
    chk("R8 ext flag", int_status, 2'b10);

    // R2 / R11 / R12 table walk
    for (int i = 0; i < 7; i++) begin
      cyc(1, VEC[i][17:10], 0, 0, 0, 0);
      chk("R2 readback", ctl_rdata, VEC[i][9:2]);
      chk("R11 pin level", irq_n_out, VEC[i][1]);
      chk("R12 pin enable", irq_oe, VEC[i][0]);
      chk("R11 flag kept", int_status, 2'b10);
    end
    cyc(1, 8'h00, 0, 0, 0, 0);

    // R9 read clears; set wins over a same-cycle read
    cyc(0, 8'h00, 1, 0, 0, 0);
    chk("R9 cleared", int_status, 2'b00);
    chk("R9 pin idle", irq_n_out, 1'b1);
    cyc(0, 8'h00, 1, 1, 0, 0);
    chk("R9 set wins", int_status, 2'b10);
    cyc(0, 8'h00, 1, 0, 0, 0);

    // R12 push-pull enable with nothing pending
    cyc(1, 8'h08, 0, 0, 0, 0);
    chk("R12 push oe", irq_oe, 1'b1);
    chk("R12 push level", irq_n_out, 1'b1);
    cyc(1, 8'h00, 0, 0, 0, 0);
    chk("R12 od oe", irq_oe, 1'b0);

    // R7 interrupt clear beats a start write
    cyc(1, 8'h04, 0, 1, 0, 0);
    chk("R7 clear wins", ctl_rdata, 8'h00);
    @(negedge clk);
    chk("R7 no fetch", fetch_req, 1'b0);
    cyc(0, 8'h00, 1, 0, 0, 0);

    // R4 manual mode blocks pointer-load start
    manual_mode = 1'b1;
    script_ptr  = 32'h0000_0400;
    cyc(0, 8'h00, 0, 0, 0, 1);
    chk("R4 manual", fetch_req, 1'b0);
    @(negedge clk);
    chk("R4 manual", fetch_req, 1'b0);
    manual_mode = 1'b0;
    cyc(0, 8'h00, 0, 0, 0, 1);
    chk("R4 auto early", fetch_req, 1'b0);
    @(negedge clk);
    chk("R4 auto fetch", fetch_req, 1'b1);
    chk("R4 auto addr", fetch_addr, 32'h0000_0400);
    @(negedge clk);
    // R5 free-running chain
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk("R5 next fetch", fetch_req, 1'b1);
    @(negedge clk);
    // R8 halt after current instruction
    cyc(0, 8'h00, 0, 1, 0, 0);
    chk("R8 still busy", busy, 1'b1);
    chk("R8 flag", int_status, 2'b10);
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk("R8 halted", busy, 1'b0);
    chk("R8 no fetch", fetch_req, 1'b0);
    cyc(0, 8'h00, 1, 0, 0, 0);

    // R3 start timing and address
    script_ptr = 32'h0000_1000;
    cyc(1, 8'h04, 0, 0, 0, 0);
    chk("R3 start read", ctl_rdata, 8'h04);
    chk("R3 early", fetch_req, 1'b0);
    @(negedge clk);
    chk("R3 fetch", fetch_req, 1'b1);
    chk("R3 addr", fetch_addr, 32'h0000_1000);
    @(negedge clk);
    chk("R3 one cycle", fetch_req, 1'b0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk("R5 refetch", fetch_req, 1'b1);
    chk("R7 start held", ctl_rdata, 8'h04);
    @(negedge clk);

    // R6 single step
    cyc(1, 8'h14, 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk("R6 step flag", int_status, 2'b01);
    chk("R6 idle", busy, 1'b0);
    chk("R7 start cleared", ctl_rdata, 8'h10);
    chk("R6 pin low", irq_n_out, 1'b0);
    @(negedge clk);
    chk("R6 no fetch", fetch_req, 1'b0);

    // R10 read and start together
    cyc(1, 8'h14, 1, 0, 0, 0);
    chk("R10 cleared", int_status, 2'b00);
    chk("R10 start", ctl_rdata, 8'h14);
    @(negedge clk);
    chk("R10 fetch", fetch_req, 1'b1);
    @(negedge clk);

    // R11 masked step interrupt, then unmask
    cyc(1, 8'h16, 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk("R11 pending", int_status, 2'b01);
    chk("R11 masked", irq_n_out, 1'b1);
    chk("R11 masked oe", irq_oe, 1'b0);
    cyc(1, 8'h10, 0, 0, 0, 0);
    chk("R11 unmask", irq_n_out, 1'b0);
    chk("R12 od drive", irq_oe, 1'b1);
    cyc(0, 8'h00, 1, 0, 0, 0);
    chk("R9 final clear", int_status, 2'b00);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule